// File: doc/BRIEF.md
# Configurable Routing Logic Cell

This block is one programmable cell of a logic fabric. It computes a Boolean function and carries other signals across at the same time. Each of its three data inputs is taken from one of several candidate wires by its own selector. The three chosen bits index an 8-entry truth table. The result can pass straight on, or it can go through a clocked storage stage first. Three output selectors then drive the cell's outputs. Each output can carry the function result or any one of the three chosen inputs. So one cell can route only, fan a signal out, compute with fanout, compute while passing its inputs on, or compute a two-input function next to an unrelated routed bit.

The first input and the first output face the vertical channel. The other two inputs and the other two outputs face the upper and lower diagonal neighbours. All programming enters through a serial shift chain, and the chain output lets cells be daisy-chained.

Top module: `rlc_cell`

## Requirements
- R1: The 21-bit configuration shifts in one bit per clock while `cfg_en` is 1, most significant bit first. `cfg_out` is the oldest bit held in the chain, so a loaded word comes back out most significant bit first. While `cfg_en` is 0 the configuration does not change.
- R2: The configuration layout, from bit 20 down to bit 0, is:
  - bits 20..13: truth table
  - bits 12..11: channel input select
  - bits 10..9: up-diagonal input select
  - bits 8..7: down-diagonal input select
  - bit 6: use-stored flag
  - bits 5..4: channel output select
  - bits 3..2: up output select
  - bits 1..0: down output select

  An input select value k picks bit k of that input's 4-bit candidate bus.
- R3: The function result is truth-table bit {down, up, channel} of the three chosen inputs, where the channel input is the least significant index bit. Any 3-input function can be programmed this way.
- R4: When the use-stored flag is 0, the function path is combinational. Outputs follow input changes in the same cycle.
- R5: When the use-stored flag is 1, the function path shows the stored bit. The stored bit takes the function result on a rising edge with `ce` 1 and `cfg_en` 0. It holds when `ce` is 0.
- R6: The stored bit holds on every edge where `cfg_en` is 1, even with `ce` 1.
- R7: Each output select works on its own output. Code 0 gives the function path. Codes 1, 2 and 3 give the chosen channel, up and down input. Different outputs may carry unrelated signals at the same time.
- R8: A synchronous active-high `rst` clears the configuration and the stored bit. All outputs and `cfg_out` then read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out |
| ce | input | 1 | Clock enable of the storage stage |
| chan_cand | input | 4 | Candidate wires for the channel input |
| up_cand | input | 4 | Candidate wires for the up-diagonal input |
| dn_cand | input | 4 | Candidate wires for the down-diagonal input |
| chan_out | output | 1 | Output to the vertical channel |
| up_out | output | 1 | Output to the up-diagonal neighbour |
| dn_out | output | 1 | Output to the down-diagonal neighbour |

## Verification
The bench reads a loaded word back through the chain. A reversed shift direction or misplaced field shows up as a bit-order mismatch, and random configurations against a model catch swapped select codes or a wrongly ordered truth-table index. It captures a value and then reloads the configuration with `ce` held high. A storage stage that kept clocking during configuration would show the new function's value instead of the old stored one. It also programs a two-input function on one output with unrelated pass-through on the other two. Output selects that were tied together or decoded from the wrong field would corrupt one of the routed signals.

// File: rtl/rlc_cell.sv
module rlc_cell #(
  parameter int N_CAND = 4,
  parameter int TT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_in,
  output logic              cfg_out,
  input  logic              ce,
  input  logic [N_CAND-1:0] chan_cand,
  input  logic [N_CAND-1:0] up_cand,
  input  logic [N_CAND-1:0] dn_cand,
  output logic              chan_out,
  output logic              up_out,
  output logic              dn_out
);
  localparam int SELW  = $clog2(N_CAND);
  localparam int OSELW = 2;
  localparam int CFG_W = TT_W + 3*SELW + 1 + 3*OSELW;
  localparam int TT_LO = CFG_W - TT_W;
  localparam int SA_LO = TT_LO - SELW;
  localparam int SB_LO = SA_LO - SELW;
  localparam int SC_LO = SB_LO - SELW;
  localparam int UR_B  = SC_LO - 1;
  localparam int O0_LO = UR_B - OSELW;
  localparam int O1_LO = O0_LO - OSELW;
  localparam int O2_LO = O1_LO - OSELW;

  logic [CFG_W-1:0] cfg;
  logic             q;
  logic             in_a, in_b, in_c, f, fp;

  always_ff @(posedge clk) begin
    if (rst)         cfg <= '0;
    else if (cfg_en) cfg <= {cfg[CFG_W-2:0], cfg_in};
  end

  assign cfg_out = cfg[CFG_W-1];

  wire [TT_W-1:0]  tt    = cfg[CFG_W-1:TT_LO];
  wire [SELW-1:0]  sel_a = cfg[SA_LO +: SELW];
  wire [SELW-1:0]  sel_b = cfg[SB_LO +: SELW];
  wire [SELW-1:0]  sel_c = cfg[SC_LO +: SELW];
  wire             use_q = cfg[UR_B];
  wire [OSELW-1:0] os0   = cfg[O0_LO +: OSELW];
  wire [OSELW-1:0] os1   = cfg[O1_LO +: OSELW];
  wire [OSELW-1:0] os2   = cfg[O2_LO +: OSELW];

  assign in_a = chan_cand[sel_a];
  assign in_b = up_cand[sel_b];
  assign in_c = dn_cand[sel_c];
  assign f    = tt[{in_c, in_b, in_a}];

  always_ff @(posedge clk) begin
    if (rst)               q <= 1'b0;
    else if (ce && !cfg_en) q <= f;
  end

  assign fp = use_q ? q : f;

  function automatic logic route(input logic [OSELW-1:0] s,
                                 input logic r, a, b, c);
    case (s)
      2'd0:    route = r;
      2'd1:    route = a;
      2'd2:    route = b;
      default: route = c;
    endcase
  endfunction

  assign chan_out = route(os0, fp, in_a, in_b, in_c);
  assign up_out   = route(os1, fp, in_a, in_b, in_c);
  assign dn_out   = route(os2, fp, in_a, in_b, in_c);
endmodule

// File: rtl/rlc_cell_chk.sv
module rlc_cell_chk #(
  parameter int CFG_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             ce,
  input logic [CFG_W-1:0] cfg,
  input logic             q,
  input logic             f
);
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (q == 1'b0 && cfg == '0));

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg));

  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (ce && !cfg_en) |=> q == $past(f));

  assert_hold_noce_R5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));

  assert_hold_cfg_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(q));
endmodule

bind rlc_cell rlc_cell_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .ce(ce),
  .cfg(cfg), .q(q), .f(f)
);

// File: tb/rlc_cell_tb.sv
module rlc_cell_tb;
  logic clk = 0, rst = 1, cfg_en = 0, cfg_in = 0, ce = 0;
  logic [3:0] vc = 0, uc = 0, dc = 0;
  logic cfg_out, chan_out, up_out, dn_out;
  int errors = 0, checks = 0;
  logic qm = 0;

  always #2 clk = ~clk;

  rlc_cell u_dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .ce(ce), .chan_cand(vc), .up_cand(uc), .dn_cand(dc),
    .chan_out(chan_out), .up_out(up_out), .dn_out(dn_out)
  );

  function automatic logic [20:0] mk(logic [7:0] tt, logic [1:0] sa, sb, sc,
                                     logic ur, logic [1:0] o0, o1, o2);
    return {tt, sa, sb, sc, ur, o0, o1, o2};
  endfunction

  function automatic logic pick(logic [1:0] s, logic r, a, b, c);
    case (s) 2'd0: return r; 2'd1: return a; 2'd2: return b; default: return c; endcase
  endfunction

  function automatic logic [2:0] model(logic [20:0] c, logic [3:0] v, u, d, logic qq);
    logic [7:0] tt; logic a, b, cc, f, fp;
    tt = c[20:13];
    a = v[c[12:11]]; b = u[c[10:9]]; cc = d[c[8:7]];
    f = tt[{cc, b, a}];
    fp = c[6] ? qq : f;
    return {pick(c[5:4], fp, a, b, cc), pick(c[3:2], fp, a, b, cc), pick(c[1:0], fp, a, b, cc)};
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load(logic [20:0] w);
    for (int i = 20; i >= 0; i--) begin
      @(negedge clk); cfg_en = 1; cfg_in = w[i];
    end
    @(negedge clk); cfg_en = 0; cfg_in = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; qm = 0;
    vc = 4'hF; uc = 4'hF; dc = 4'hF;
    #0.5;
    chk("R8 outputs", {chan_out, up_out, dn_out}, 3'b000);
    chk("R8 cfg_out", {2'b00, cfg_out}, 3'b000);
  endtask

  task automatic t_chain();
    logic [20:0] p;
    p = 21'h15A3C9;
    load(p);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); cfg_in = ~cfg_in; vc = 4'(i*3); uc = 4'(i+5); dc = 4'(~i);
      #0.5;
      chk("R1 frozen while cfg_en low", {chan_out, up_out, dn_out}, model(p, vc, uc, dc, qm));
    end
    for (int i = 0; i < 21; i++) begin
      @(negedge clk); cfg_en = 1; cfg_in = 0;
      #0.5;
      chk("R1 chain readback", {2'b00, cfg_out}, {2'b00, p[20-i]});
    end
    @(negedge clk); cfg_en = 0;
  endtask

  task automatic t_tt();
    logic [7:0] tts [4] = '{8'h96, 8'h01, 8'h80, 8'h5A};
    foreach (tts[k]) begin
      load(mk(tts[k], 0, 0, 0, 0, 0, 0, 0));
      for (int idx = 0; idx < 8; idx++) begin
        @(negedge clk);
        vc = {3'b0, idx[0]}; uc = {3'b0, idx[1]}; dc = {3'b0, idx[2]};
        #0.5;
        chk("R3 truth table index", {chan_out, up_out, dn_out}, {3{tts[k][idx]}});
      end
    end
  endtask

  task automatic t_random();
    logic [20:0] w;
    for (int n = 0; n < 30; n++) begin
      w = 21'($urandom); w[6] = 0;
      load(w);
      for (int m = 0; m < 4; m++) begin
        @(negedge clk); vc = 4'($urandom); uc = 4'($urandom); dc = 4'($urandom);
        #0.5;
        chk("R2 R4 R7 random config", {chan_out, up_out, dn_out}, model(w, vc, uc, dc, qm));
      end
    end
  endtask

  task automatic t_stored();
    logic [20:0] w;
    w = mk(8'hE8, 0, 0, 0, 1, 0, 1, 0);
    load(w);
    @(negedge clk); vc = 4'h1; uc = 4'h1; dc = 4'h0; ce = 1;
    @(negedge clk); ce = 0; qm = 1; vc = 0; uc = 0; dc = 0;
    #0.5;
    chk("R5 captured value", {chan_out, up_out, dn_out}, {1'b1, 1'b0, 1'b1});
    @(negedge clk); #0.5;
    chk("R5 hold with ce low", {chan_out, up_out, dn_out}, model(w, vc, uc, dc, qm));
    @(negedge clk); ce = 1;
    @(negedge clk); ce = 0; qm = 0; #0.5;
    chk("R5 recapture zero", {chan_out, up_out, dn_out}, 3'b000);
  endtask

  task automatic t_cfg_hold();
    load(mk(8'hFF, 0, 0, 0, 1, 0, 0, 0));
    @(negedge clk); ce = 1;
    @(negedge clk); qm = 1; #0.5;
    chk("R5 stored one", {chan_out, up_out, dn_out}, 3'b111);
    load(mk(8'h00, 0, 0, 0, 1, 0, 1, 0));
    #0.5;
    chk("R6 hold through config", {chan_out, up_out, dn_out}, {1'b1, vc[0], 1'b1});
    @(negedge clk); ce = 0; qm = 0; #0.5;
    chk("R6 capture after config", {chan_out, up_out, dn_out}, {1'b0, vc[0], 1'b0});
  endtask

  task automatic t_disjoint();
    logic [20:0] w;
    w = mk(8'h88, 2, 1, 3, 0, 0, 3, 1);
    load(w);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      vc = i[0] ? 4'b0100 : 4'b1011;
      uc = i[1] ? 4'b0010 : 4'b1101;
      dc = i[2] ? 4'b1000 : 4'b0111;
      #0.5;
      chk("R7 disjoint routing", {chan_out, up_out, dn_out}, {i[0] & i[1], i[2], i[0]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_chain();
    t_tt();
    t_random();
    t_stored();
    t_cfg_hold();
    t_disjoint();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule